// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block takes a single oscillator input and produces three clocks from it: the processor clock and two peripheral clock pins. One byte-wide control register sets all three. The processor clock runs at the oscillator rate or at half of it. The first peripheral pin can carry the oscillator, the oscillator halved, or the oscillator divided by 1.5. The second peripheral pin offers four divisors (6, 7.5, 10, 12). These divisors give a 1.8432 MHz serial-port clock from the usual crystal frequencies. Each peripheral pin has its own enable, and a disabled pin sits at 0.

Every output comes from one shared divider core. The core counts oscillator half-periods, so fractional divisors come out with a duty cycle that is within half an oscillator period of 50%. A new divisor or enable is taken up only once the output is in its low phase, so no shortened high pulse ever appears. Bit 7 of the register is an activity flag. An activity event sets it, and reading the register clears it. While the flag is set, the `sleep_blocked` output is high. After reset, or after the oscillator has been halted, the block counts three good oscillator rising edges before it releases any clock.

Top module: `clkout_gen`

## Requirements
- R1: In reset the register reads 00h, all three clock outputs are 0, `clk_ready` is 0 and `sleep_blocked` is 0. A write stores `wr_data[6:0]` into bits 6:0, and these bits read back unchanged on `rd_data[6:0]` from the next cycle.
- R2: With bit 5 = 0, `cpu_clk` follows the oscillator (period 2 half-periods, high for 1). With bit 5 = 1, it is the oscillator divided by 2 (period 4, high for 2).
- R3: With bit 4 = 1, bits 3:2 set the `clk2_out` divisor as follows: 00 gives /7.5 (period 15 half-periods, high 7), 01 gives /6 (12, high 6), 10 gives /12 (24, high 12) and 11 gives /10 (20, high 10).
- R4: With bit 1 = 0, `clk1_out` is held at 0. With bit 4 = 0, `clk2_out` is held at 0.
- R5: With bit 1 = 1 and bit 0 = 0 (bit 6 = 0), `clk1_out` equals the oscillator. With bit 1 = 1 and bit 0 = 1, `clk1_out` is the oscillator divided by 2, whatever the value of bit 6.
- R6: With bit 6 = 1, bit 1 = 1 and bit 0 = 0, `clk1_out` is the oscillator divided by 1.5: a period of 3 half-periods with 1 half-period high.
- R7: Bit 7 of `rd_data` is the activity flag, and `sleep_blocked` is high exactly while it is set. An `act_evt` pulse sets it. A read (`rd_en`) clears it, but an event in the same cycle wins over the read. Writes never change bit 7.
- R8: `clk_ready` rises on the third oscillator rising edge counted after reset release (after the two-stage reset synchroniser) or after `osc_halt` falls. While `osc_halt` is 1, `clk_ready` is 0 and all three clocks stop low.
- R9: A divisor or enable change takes effect only after a low half-period of the output. Every high pulse therefore has the full length of the setting in force when it began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator input; every register is clocked by it |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_halt | input | 1 | High while the oscillator is stopped or restarting |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; clears the activity flag |
| wr_data | input | 8 | Register write data (bit 7 is ignored) |
| act_evt | input | 1 | Activity event; sets the activity flag |
| rd_data | output | 8 | Register contents: activity flag and bits 6:0 |
| sleep_blocked | output | 1 | High while the activity flag is set |
| clk_ready | output | 1 | High once the start-up count has completed |
| cpu_clk | output | 1 | Processor clock |
| clk1_out | output | 1 | First peripheral clock pin |
| clk2_out | output | 1 | Second peripheral clock pin |

## Verification
The checker tests the register side on every cycle: the activity flag is set by an event and cleared by a read, bits 6:0 read back what was written, and `clk_ready` appears only after three edges with the oscillator running. It also checks that each disabled pin, and every clock while not ready, has settled low within a bounded number of cycles. Exact periods and high-phase lengths for each divisor, including the fractional 1.5 and 7.5, are measured only by the bench's half-period sampling scenarios. The same holds for the rule that no high pulse is cut short when a divisor or enable changes mid-pulse.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  // Width of a period expressed in oscillator half-periods.
  localparam int HPW = 5;
  typedef logic [HPW-1:0] hp_t;

  // Periods in half-periods (twice the divisor).
  localparam hp_t HP_DIV1   = hp_t'(2);
  localparam hp_t HP_DIV1P5 = hp_t'(3);
  localparam hp_t HP_DIV2   = hp_t'(4);
  localparam hp_t HP_DIV6   = hp_t'(12);
  localparam hp_t HP_DIV7P5 = hp_t'(15);
  localparam hp_t HP_DIV10  = hp_t'(20);
  localparam hp_t HP_DIV12  = hp_t'(24);

  // Number of divided outputs and their slots.
  localparam int NOUT     = 3;
  localparam int OUT_CPU  = 0;
  localparam int OUT_CLK1 = 1;
  localparam int OUT_CLK2 = 2;

  function automatic hp_t cpu_period(input logic half_rate);
    return half_rate ? HP_DIV2 : HP_DIV1;
  endfunction

  function automatic hp_t clk1_period(input logic frac_sel, input logic src_sel);
    if (src_sel)       return HP_DIV2;
    else if (frac_sel) return HP_DIV1P5;
    else               return HP_DIV1;
  endfunction

  function automatic hp_t clk2_period(input logic [1:0] code);
    case (code)
      2'b00:   return HP_DIV7P5;
      2'b01:   return HP_DIV6;
      2'b10:   return HP_DIV12;
      default: return HP_DIV10;
    endcase
  endfunction
endpackage

// File: rtl/clkout_start.sv
// Reset synchroniser and oscillator start-up pulse counter.
module clkout_start #(
  parameter int SYNC_STAGES = 2,
  parameter int GOOD_PULSES = 3
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic osc_halt,
  output logic rst_sync_n,
  output logic ready
);
  localparam int CW = $clog2(GOOD_PULSES + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(GOOD_PULSES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_n;
  logic                   ready_q;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (osc_halt)              cnt_n = '0;
    else if (cnt_q == CNT_DONE) cnt_n = cnt_q;
    else                        cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge osc_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      ready_q <= (cnt_n == CNT_DONE);
    end
  end
  assign ready = ready_q;
endmodule

// File: rtl/clkout_ctrl_reg.sv
// Control register with a clear-on-read activity flag in bit 7.
module clkout_ctrl_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          act_evt,
  output logic [DW-2:0] cfg,
  output logic          act
);
  logic [DW-2:0] cfg_q, cfg_n;
  logic          act_q, act_n;

  always_comb begin
    cfg_n = wr_en ? wr_data[DW-2:0] : cfg_q;
    if (act_evt)    act_n = 1'b1;
    else if (rd_en) act_n = 1'b0;
    else            act_n = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      act_q <= 1'b0;
    end else begin
      cfg_q <= cfg_n;
      act_q <= act_n;
    end
  end

  assign cfg = cfg_q;
  assign act = act_q;
endmodule

// File: rtl/clkout_frac_div.sv
// Half-period divider: period of P half-periods, high for floor(P/2).
// The first-half level is registered on the rising edge and the second-half
// level on the falling edge; the oscillator level picks between them.
module clkout_frac_div
  import clkout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  hp_t  p_req,
  output logic clk_o
);
  hp_t          h_q, p_q, h_n, p_n, h_inc1;
  logic [HPW:0] h_inc2;
  logic         en_q, en_n;
  logic         sec_lvl, first_n, adopt;
  logic         hi1_q, hi2_q;

  always_comb begin
    h_inc1  = (h_q + 1'b1 == p_q) ? '0 : hp_t'(h_q + 1'b1);
    sec_lvl = en_q && (h_inc1 < (p_q >> 1));
    h_inc2  = {1'b0, h_q} + (HPW+1)'(2);
    adopt   = ((en_req != en_q) || (p_req != p_q)) && !sec_lvl;
    if (adopt) begin
      h_n  = '0;
      p_n  = p_req;
      en_n = en_req;
    end else begin
      p_n  = p_q;
      en_n = en_q;
      if (!en_q)                       h_n = '0;
      else if (h_inc2 >= {1'b0, p_q})  h_n = hp_t'(h_inc2 - {1'b0, p_q});
      else                             h_n = hp_t'(h_inc2);
    end
    first_n = en_n && (h_n < (p_n >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q   <= '0;
      p_q   <= HP_DIV1;
      en_q  <= 1'b0;
      hi1_q <= 1'b0;
    end else begin
      h_q   <= h_n;
      p_q   <= p_n;
      en_q  <= en_n;
      hi1_q <= first_n;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hi2_q <= 1'b0;
    else        hi2_q <= sec_lvl;
  end

  assign clk_o = clk ? hi1_q : hi2_q;
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_pkg::*;
(
  input  logic       osc_clk,
  input  logic       rst_n,
  input  logic       osc_halt,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  input  logic       act_evt,
  output logic [7:0] rd_data,
  output logic       sleep_blocked,
  output logic       clk_ready,
  output logic       cpu_clk,
  output logic       clk1_out,
  output logic       clk2_out
);
  logic            rst_sync_n;
  logic            ready;
  logic [6:0]      cfg;
  logic            act;
  logic [NOUT-1:0] en_req;
  hp_t             p_req [NOUT];
  logic [NOUT-1:0] clk_vec;

  clkout_start #(.SYNC_STAGES(2), .GOOD_PULSES(3)) u_start (
    .osc_clk    (osc_clk),
    .rst_n      (rst_n),
    .osc_halt   (osc_halt),
    .rst_sync_n (rst_sync_n),
    .ready      (ready)
  );

  clkout_ctrl_reg #(.DW(8)) u_reg (
    .clk     (osc_clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .act_evt (act_evt),
    .cfg     (cfg),
    .act     (act)
  );

  always_comb begin
    en_req[OUT_CPU]  = ready;
    p_req[OUT_CPU]   = cpu_period(cfg[5]);
    en_req[OUT_CLK1] = ready && cfg[1];
    p_req[OUT_CLK1]  = clk1_period(cfg[6], cfg[0]);
    en_req[OUT_CLK2] = ready && cfg[4];
    p_req[OUT_CLK2]  = clk2_period(cfg[3:2]);
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_div
    clkout_frac_div u_div (
      .clk    (osc_clk),
      .rst_n  (rst_sync_n),
      .en_req (en_req[g]),
      .p_req  (p_req[g]),
      .clk_o  (clk_vec[g])
    );
  end

  assign cpu_clk       = clk_vec[OUT_CPU];
  assign clk1_out      = clk_vec[OUT_CLK1];
  assign clk2_out      = clk_vec[OUT_CLK2];
  assign rd_data       = {act, cfg};
  assign sleep_blocked = act;
  assign clk_ready     = ready;
endmodule

// File: rtl/clkout_gen_checker.sv
module clkout_gen_checker (
  input logic       osc_clk,
  input logic       rst_n,
  input logic       osc_halt,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wr_data,
  input logic       act_evt,
  input logic [7:0] rd_data,
  input logic       clk_ready,
  input logic       cpu_clk,
  input logic       clk1_out,
  input logic       clk2_out
);
  localparam int SETTLE = 30;
  localparam int CW     = 6;

  logic [CW-1:0] off1_cnt, off2_cnt, nrdy_cnt;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      off1_cnt <= '0;
      off2_cnt <= '0;
      nrdy_cnt <= '0;
    end else begin
      off1_cnt <= rd_data[1] ? '0 : ((off1_cnt == '1) ? off1_cnt : off1_cnt + 1'b1);
      off2_cnt <= rd_data[4] ? '0 : ((off2_cnt == '1) ? off2_cnt : off2_cnt + 1'b1);
      nrdy_cnt <= clk_ready  ? '0 : ((nrdy_cnt == '1) ? nrdy_cnt : nrdy_cnt + 1'b1);
    end
  end

  a_r7_evt_sets: assert property (@(posedge osc_clk) disable iff (!rst_n)
    act_evt |=> rd_data[7]);

  a_r7_read_clears: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (rd_en && !act_evt) |=> !rd_data[7]);

  a_r1_readback: assert property (@(posedge osc_clk) disable iff (!rst_n)
    wr_en |=> (rd_data[6:0] == $past(wr_data[6:0])));

  a_r8_ready_delay: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(clk_ready) |-> (!$past(osc_halt, 1) && !$past(osc_halt, 2) && !$past(osc_halt, 3)));

  a_r8_halt_drops: assert property (@(posedge osc_clk) disable iff (!rst_n)
    osc_halt |=> !clk_ready);

  a_r8_stopped_low: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (nrdy_cnt >= CW'(4)) |-> !cpu_clk);

  a_r4_clk1_held: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (off1_cnt >= CW'(SETTLE)) |-> !clk1_out);

  a_r4_clk2_held: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (off2_cnt >= CW'(SETTLE)) |-> !clk2_out);
endmodule

bind clkout_gen clkout_gen_checker u_checker (
  .osc_clk   (osc_clk),
  .rst_n     (rst_n),
  .osc_halt  (osc_halt),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .wr_data   (wr_data),
  .act_evt   (act_evt),
  .rd_data   (rd_data),
  .clk_ready (clk_ready),
  .cpu_clk   (cpu_clk),
  .clk1_out  (clk1_out),
  .clk2_out  (clk2_out)
);

// File: tb/clkout_gen_bench.sv
`timescale 1ns/1ps
module clkout_gen_bench;
  logic       osc_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_halt = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       act_evt = 1'b0;
  logic [7:0] rd_data;
  logic       sleep_blocked, clk_ready, cpu_clk, clk1_out, clk2_out;

  int checks = 0;
  int fails  = 0;
  int hi_run = 0;
  int min_hi2 = 1000;

  always #5 osc_clk = ~osc_clk;

  clkout_gen u_clkout_gen (
    .osc_clk(osc_clk), .rst_n(rst_n), .osc_halt(osc_halt), .wr_en(wr_en),
    .rd_en(rd_en), .wr_data(wr_data), .act_evt(act_evt), .rd_data(rd_data),
    .sleep_blocked(sleep_blocked), .clk_ready(clk_ready), .cpu_clk(cpu_clk),
    .clk1_out(clk1_out), .clk2_out(clk2_out)
  );

  // Passive monitor of clk2 high-pulse lengths in half-periods (R9).
  always @(osc_clk) begin
    #2;
    if (clk2_out) hi_run++;
    else begin
      if (hi_run > 0 && hi_run < min_hi2) min_hi2 = hi_run;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge osc_clk); #2;
    wr_en = 1'b1; wr_data = d;
    @(posedge osc_clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge osc_clk);
    #2;
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return cpu_clk;
      1: return clk1_out;
      default: return clk2_out;
    endcase
  endfunction

  // Measure period and high length in half-periods on one output.
  task automatic measure(input int sel, input int exp_p, input string req);
    logic lv [120];
    int r1, f, r2;
    r1 = -1; f = -1; r2 = -1;
    cycles(40);
    for (int i = 0; i < 120; i++) begin
      @(osc_clk); #2;
      lv[i] = pick(sel);
    end
    for (int i = 1; i < 120; i++)
      if (r1 < 0 && !lv[i-1] && lv[i]) r1 = i;
    if (r1 >= 0) for (int i = r1 + 1; i < 120; i++)
      if (f < 0 && !lv[i]) f = i;
    if (f >= 0) for (int i = f + 1; i < 120; i++)
      if (r2 < 0 && !lv[i-1] && lv[i]) r2 = i;
    chk(r2 >= 0, req, r2, 1);
    if (r2 >= 0) begin
      chk(r2 - r1 == exp_p, req, r2 - r1, exp_p);
      chk(f - r1 == exp_p / 2, req, f - r1, exp_p / 2);
    end
  endtask

  task automatic held_low(input int sel, input string req);
    int highs;
    highs = 0;
    cycles(40);
    for (int i = 0; i < 60; i++) begin
      @(osc_clk); #2;
      if (pick(sel)) highs++;
    end
    chk(highs == 0, req, highs, 0);
  endtask

  task automatic t_reset_startup;
    #2;
    chk(rd_data == 8'h00, "R1 reset reg", rd_data, 0);
    chk({cpu_clk, clk1_out, clk2_out} == 3'b000, "R1 reset clocks", {cpu_clk, clk1_out, clk2_out}, 0);
    chk(clk_ready == 1'b0, "R1 reset ready", clk_ready, 0);
    chk(sleep_blocked == 1'b0, "R1 reset sleep_blocked", sleep_blocked, 0);
    @(negedge osc_clk); #2;
    rst_n = 1'b1;
    cycles(4);
    chk(clk_ready == 1'b0, "R8 ready early", clk_ready, 0);
    cycles(1);
    chk(clk_ready == 1'b1, "R8 ready on time", clk_ready, 1);
  endtask

  task automatic t_cpu;
    wr(8'h00);
    measure(0, 2, "R2 cpu /1");
    wr(8'h20);
    chk(rd_data == 8'h20, "R1 readback", rd_data, 8'h20);
    measure(0, 4, "R2 cpu /2");
    wr(8'h00);
  endtask

  task automatic t_clk1;
    held_low(1, "R4 clk1 disabled");
    wr(8'h02); measure(1, 2, "R5 clk1 osc");
    wr(8'h03); measure(1, 4, "R5 clk1 /2");
    wr(8'h43); measure(1, 4, "R5 clk1 /2 with bit6");
    wr(8'h42); measure(1, 3, "R6 clk1 /1.5");
    wr(8'h40); held_low(1, "R4 clk1 disabled bit6");
  endtask

  task automatic t_clk2;
    held_low(2, "R4 clk2 disabled");
    wr(8'h10); measure(2, 15, "R3 clk2 /7.5");
    wr(8'h14); measure(2, 12, "R3 clk2 /6");
    wr(8'h18); measure(2, 24, "R3 clk2 /12");
    wr(8'h1C); measure(2, 20, "R3 clk2 /10");
    wr(8'h0C); held_low(2, "R4 clk2 disabled after run");
  endtask

  task automatic t_no_runt;
    wr(8'h18);
    cycles(40);
    min_hi2 = 1000;
    cycles(7);  wr(8'h14);
    cycles(5);  wr(8'h00);
    cycles(3);  wr(8'h1C);
    cycles(9);  wr(8'h18);
    cycles(60);
    chk(min_hi2 >= 6, "R9 no runt pulse", min_hi2, 6);
    wr(8'h00);
    cycles(40);
  endtask

  task automatic t_activity;
    @(negedge osc_clk); #2; act_evt = 1'b1;
    @(posedge osc_clk); #2; act_evt = 1'b0;
    chk(rd_data[7] == 1'b1, "R7 set by event", rd_data[7], 1);
    chk(sleep_blocked == 1'b1, "R7 sleep blocked", sleep_blocked, 1);
    @(negedge osc_clk); #2; rd_en = 1'b1;
    @(posedge osc_clk); #2; rd_en = 1'b0;
    chk(rd_data[7] == 1'b0, "R7 read clears", rd_data[7], 0);
    chk(sleep_blocked == 1'b0, "R7 sleep unblocked", sleep_blocked, 0);
    @(negedge osc_clk); #2; rd_en = 1'b1; act_evt = 1'b1;
    @(posedge osc_clk); #2; rd_en = 1'b0; act_evt = 1'b0;
    chk(rd_data[7] == 1'b1, "R7 event wins", rd_data[7], 1);
    @(negedge osc_clk); #2; rd_en = 1'b1;
    @(posedge osc_clk); #2; rd_en = 1'b0;
    wr(8'hFF);
    chk(rd_data == 8'h7F, "R7 write ignores bit7", rd_data, 8'h7F);
    chk(sleep_blocked == 1'b0, "R7 write no block", sleep_blocked, 0);
    wr(8'h00);
    chk(rd_data == 8'h00, "R1 readback zero", rd_data, 0);
  endtask

  task automatic t_halt;
    @(negedge osc_clk); #2; osc_halt = 1'b1;
    cycles(1);
    chk(clk_ready == 1'b0, "R8 halt drops ready", clk_ready, 0);
    held_low(0, "R8 cpu stopped in halt");
    @(negedge osc_clk); #2; osc_halt = 1'b0;
    cycles(2);
    chk(clk_ready == 1'b0, "R8 restart early", clk_ready, 0);
    cycles(1);
    chk(clk_ready == 1'b1, "R8 restart on time", clk_ready, 1);
    measure(0, 2, "R8 cpu resumes");
  endtask

  initial begin
    t_reset_startup();
    t_cpu();
    t_clk1();
    t_clk2();
    t_no_runt();
    t_activity();
    t_halt();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule